// File: doc/BRIEF.md
# Register-Select Serial Host Port

This block is a slave serial port through which a host reads a 24-bit conversion result or a 16-bit status word, and writes a 16-bit configuration word. The host frames each transfer with an active-low chip select. The read/write line and the register-select line are captured when the frame opens. During a read, the chosen word leaves MSB first on the serial data output, and an output-enable tells the pad when to drive. During a write, bits enter MSB first through an input shift register. The configuration word is loaded once 16 bits have arrived.

Every host-side input passes through a two-flop synchroniser into the system clock domain. Serial clock edges are then found by comparing the synchronised clock with its previous value. The producer of results delivers each word with a one-cycle valid pulse. A data-ready flag tells the host that an unread result is waiting. A result that arrives while the conversion word is being shifted out goes into a shadow register, so the word in flight is never disturbed.

Top module: `hsp_port`

## Requirements
- R1: While cs_ni is high, sdo_oe_o stays low, and toggling sclk_i, sdi_i and rw_i leaves cfg_o unchanged.
- R2: rw_i sampled high when cs_ni falls opens a read frame, in which sdo_oe_o is high. rw_i low opens a write frame, in which sdo_oe_o stays low.
- R3: In a read frame, rsel_i sampled high when cs_ni falls selects the 24-bit conversion word. rsel_i low selects the 16-bit status_i value captured when the frame opens.
- R4: In a read frame, the MSB is on sdo_o before the first sclk_i rising edge. The first rising edge does not advance the output, and each later rising edge advances it by one bit. sdo_o is stable between rising edges, so the host samples each bit on the falling edge.
- R5: In a write frame, sdi_i is sampled on each sclk_i falling edge, MSB first. cfg_o takes the 16-bit word at the 16th falling edge, and further edges in the same frame are ignored.
- R6: drdy_o rises when res_vld_i delivers a result and falls after the 24th falling edge of a conversion read. A status read, or a conversion read aborted early, leaves drdy_o high.
- R7: A result delivered during a conversion read goes into a shadow register and sets drdy_o. The word being shifted is unchanged, and the next conversion read returns the new result. This holds whether the read completes or is aborted.
- R8: A write frame closed by cs_ni rising before 16 falling edges leaves cfg_o unchanged.
- R9: A result delivered in the same cycle as a conversion read completes leaves drdy_o high, and the next conversion read returns that result.
- R10: After reset, drdy_o and sdo_oe_o are 0 and cfg_o equals CFG_RST (default 16'h0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| rsel_i | input | 1 | Read source: 1 conversion word, 0 status |
| sclk_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the sdo pad |
| drdy_o | output | 1 | Unread result available |
| res_i | input | DATA_W | New conversion result |
| res_vld_i | input | 1 | One-cycle strobe for res_i |
| status_i | input | STAT_W | Live status word |
| cfg_o | output | CFG_W | Configuration register |

## Verification
Two events can fall in the same system cycle: the completion of a conversion read, which clears data-ready, and the arrival of a new result, which sets it. The bench counts the register stages between the serial clock pin and the edge-detect logic. It then drives res_vld_i in exactly the cycle in which the 24th falling edge takes effect. The outcome is judged at the ports: drdy_o must be high after the frame, and the next conversion read must return the new word rather than the one just read.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int unsigned DATA_W_DEF = 24;
  localparam int unsigned STAT_W_DEF = 16;
  localparam int unsigned CFG_W_DEF  = 16;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned STAT_W = 16,
  localparam int unsigned SH_W  = hsp_pkg::max_w(DATA_W, STAT_W),
  localparam int unsigned CNT_W = $clog2(SH_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_data_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              bit_o,
  output logic              fin_o,
  output logic              done_o
);
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q, len_q;
  logic             fin_q;

  assign done_o = fall_i && !fin_q && (cnt_q + 1'b1 == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      len_q <= '0;
      fin_q <= 1'b1;
    end else if (load_i) begin
      // left-align the chosen word so the MSB sits at the top
      sh_q  <= sel_data_i ? (SH_W'(data_i) << (SH_W - DATA_W))
                          : (SH_W'(stat_i) << (SH_W - STAT_W));
      len_q <= sel_data_i ? CNT_W'(DATA_W) : CNT_W'(STAT_W);
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      // first rising edge only opens the frame; later ones launch the next bit
      if (rise_i && !fin_q && cnt_q != '0) sh_q <= sh_q << 1;
      if (fall_i && !fin_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (done_o) fin_q <= 1'b1;
      end
    end
  end

  assign bit_o = sh_q[SH_W-1];
  assign fin_o = fin_q;
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx #(
  parameter int unsigned CFG_W = 16,
  parameter logic [CFG_W-1:0] CFG_RST = '0,
  localparam int unsigned CNT_W = $clog2(CFG_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fall_i,
  input  logic             bit_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] sh_q, cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[CFG_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      cfg_q <= CFG_RST;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (fall_i && cnt_q < CNT_W'(CFG_W)) begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(CFG_W - 1)) cfg_q <= sh_nxt;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/hsp_result.sv
module hsp_result #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              vld_i,
  input  logic              hold_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] word_o,
  output logic              rdy_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] out_q, shadow_q;
  logic              pend_q, rdy_q;
  logic              move;

  assign move = pend_q && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      if (vld_i && hold_i) begin
        shadow_q <= res_i;
        pend_q   <= 1'b1;
      end else if (vld_i) begin
        out_q  <= res_i;
        pend_q <= 1'b0;
      end else if (move) begin
        out_q  <= shadow_q;
        pend_q <= 1'b0;
      end
      // a pending word keeps the flag up across a completing read
      if (vld_i || move)  rdy_q <= 1'b1;
      else if (done_i)    rdy_q <= pend_q;
    end
  end

  assign word_o = out_q;
  assign rdy_o  = rdy_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/hsp_port.sv
module hsp_port #(
  parameter int unsigned DATA_W = hsp_pkg::DATA_W_DEF,
  parameter int unsigned STAT_W = hsp_pkg::STAT_W_DEF,
  parameter int unsigned CFG_W  = hsp_pkg::CFG_W_DEF,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic              rsel_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              drdy_o,
  input  logic [DATA_W-1:0] res_i,
  input  logic              res_vld_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [CFG_W-1:0]  cfg_o
);
  logic cs_s, rw_s, sel_s, sclk_s, sdi_s;
  logic cs_q, sclk_q;
  logic frm_start, frm_active, sclk_rise, sclk_fall;
  logic rd_mode_q, sel_data_q, rd_active;
  logic tx_bit, tx_fin, tx_done;
  logic data_done, data_hold, pend;
  logic [DATA_W-1:0] out_word;

  hsp_sync #(.W(5), .RST_VAL(5'b10000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rw_i, rsel_i, sclk_i, sdi_i}),
    .q_o   ({cs_s, rw_s, sel_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      sclk_q     <= 1'b0;
      rd_mode_q  <= 1'b0;
      sel_data_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      if (frm_start) begin
        rd_mode_q  <= rw_s;
        sel_data_q <= sel_s;
      end
    end
  end

  assign frm_start  = cs_q && !cs_s;
  assign frm_active = !cs_q && !cs_s;
  assign sclk_rise  = frm_active && sclk_s && !sclk_q;
  assign sclk_fall  = frm_active && !sclk_s && sclk_q;
  assign rd_active  = frm_active && rd_mode_q;

  hsp_tx #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (frm_start && rw_s),
    .sel_data_i(sel_s),
    .data_i    (out_word),
    .stat_i    (status_i),
    .rise_i    (sclk_rise && rd_mode_q),
    .fall_i    (sclk_fall && rd_mode_q),
    .bit_o     (tx_bit),
    .fin_o     (tx_fin),
    .done_o    (tx_done)
  );

  hsp_rx #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(frm_start),
    .fall_i (sclk_fall && !rd_mode_q),
    .bit_i  (sdi_s),
    .cfg_o  (cfg_o)
  );

  assign data_done = tx_done && sel_data_q;
  // hold the output word from the load cycle until the last bit is out
  assign data_hold = (frm_start && rw_s && sel_s) ||
                     (rd_active && sel_data_q && !tx_fin);

  hsp_result #(.DATA_W(DATA_W)) u_res (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .res_i (res_i),
    .vld_i (res_vld_i),
    .hold_i(data_hold),
    .done_i(data_done),
    .word_o(out_word),
    .rdy_o (drdy_o),
    .pend_o(pend)
  );

  assign sdo_oe_o = rd_active;
  assign sdo_o    = rd_active && tx_bit;
endmodule

// File: rtl/hsp_port_checker.sv
module hsp_port_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CFG_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              drdy_o,
  input logic              res_vld_i,
  input logic [CFG_W-1:0]  cfg_o,
  input logic              rd_mode_q,
  input logic              frm_active,
  input logic              rd_active,
  input logic              sclk_rise,
  input logic              data_done,
  input logic              data_hold,
  input logic              pend,
  input logic [DATA_W-1:0] out_word
);
  assert_oe_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_oe_o);

  assert_sdo_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_active && !sclk_rise) |=> (!sdo_oe_o || $stable(sdo_o)));

  assert_cfg_write_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(frm_active && !rd_mode_q));

  assert_rdy_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_i |=> drdy_o);

  assert_rdy_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && !res_vld_i && !pend) |=> !drdy_o);

  assert_word_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_hold |=> $stable(out_word));
endmodule

bind hsp_port hsp_port_checker #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o),
  .drdy_o    (drdy_o),
  .res_vld_i (res_vld_i),
  .cfg_o     (cfg_o),
  .rd_mode_q (rd_mode_q),
  .frm_active(frm_active),
  .rd_active (rd_active),
  .sclk_rise (sclk_rise),
  .data_done (data_done),
  .data_hold (data_hold),
  .pend      (pend),
  .out_word  (out_word)
);

// File: tb/hsp_port_bench.sv
`timescale 1ns/1ps
module hsp_port_bench;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rw = 1'b0, rsel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        res_vld = 1'b0;
  logic [23:0] res = '0;
  logic [15:0] status = '0;
  logic        sdo, sdo_oe, drdy;
  logic [15:0] cfg;

  int n_chk = 0, n_bad = 0;
  bit all_done = 0;

  always #4 clk = ~clk;

  hsp_port u_hsp_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .rsel_i(rsel),
    .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .drdy_o(drdy),
    .res_i(res), .res_vld_i(res_vld), .status_i(status), .cfg_o(cfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame(input logic r, input logic s);
    @(negedge clk); rw = r; rsel = s;
    wait_n(4); cs_n = 1'b0;
    wait_n(HP);
  endtask

  task automatic close_frame();
    @(negedge clk); cs_n = 1'b1;
    wait_n(HP);
  endtask

  task automatic push(input logic [23:0] v);
    @(negedge clk); res = v; res_vld = 1'b1;
    @(negedge clk); res_vld = 1'b0;
    wait_n(2);
  endtask

  task automatic read_bits(input int n, output logic [31:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1;
      wait_n(HP - 1);
      v = {v[30:0], sdo};
      sclk = 1'b0;
      wait_n(HP);
    end
  endtask

  task automatic write_bits(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdi = v[i];
      wait_n(HP - 1);
      sclk = 1'b1;
      wait_n(HP);
      sclk = 1'b0;
    end
    wait_n(HP);
  endtask

  task automatic t_reset();
    check("R10 drdy", drdy, 0);
    check("R10 oe", sdo_oe, 0);
    check("R10 cfg", cfg, 16'h0000);
  endtask

  task automatic t_idle();
    logic oe_seen = 1'b0;
    @(negedge clk); rw = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); sdi = i[0]; rw = i[1]; sclk = 1'b1;
      wait_n(HP); oe_seen |= sdo_oe; sclk = 1'b0;
      wait_n(HP); oe_seen |= sdo_oe;
    end
    check("R1 oe idle", oe_seen, 0);
    check("R1 cfg ignored", cfg, 16'h0000);
  endtask

  task automatic t_write();
    open_frame(1'b0, 1'b1);
    check("R2 oe in write", sdo_oe, 0);
    write_bits(16, 32'hA5C3);
    close_frame();
    check("R5 cfg load", cfg, 16'hA5C3);
    open_frame(1'b0, 1'b0);
    write_bits(20, 32'h1234F);
    close_frame();
    check("R5 extra bits ignored", cfg, 16'h1234);
  endtask

  task automatic t_abort();
    open_frame(1'b0, 1'b0);
    write_bits(10, 32'h3FF);
    close_frame();
    check("R8 aborted write", cfg, 16'h1234);
  endtask

  task automatic t_data_read();
    logic [31:0] v;
    push(24'hC3A5F1);
    check("R6 drdy set", drdy, 1);
    open_frame(1'b1, 1'b1);
    check("R2 oe in read", sdo_oe, 1);
    check("R4 msb before first edge", sdo, 1);
    read_bits(24, v);
    check("R3 R4 data word", v, 32'hC3A5F1);
    check("R6 drdy cleared", drdy, 0);
    close_frame();
    check("R1 oe after frame", sdo_oe, 0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    push(24'h123456);
    status = 16'h8E71;
    open_frame(1'b1, 1'b0);
    status = 16'h0000;
    read_bits(16, v);
    close_frame();
    check("R3 status word", v, 32'h8E71);
    check("R6 drdy kept after status read", drdy, 1);
    open_frame(1'b1, 1'b1);
    read_bits(8, v);
    close_frame();
    check("R3 partial data", v, 32'h12);
    check("R6 drdy kept after abort", drdy, 1);
  endtask

  task automatic t_shadow();
    logic [31:0] v, w;
    push(24'h111111);
    open_frame(1'b1, 1'b1);
    read_bits(8, v);
    push(24'h222222);
    read_bits(16, w);
    close_frame();
    check("R7 word in flight", {v[7:0], w[15:0]}, 32'h111111);
    check("R7 drdy after shadow", drdy, 1);
    open_frame(1'b1, 1'b1);
    read_bits(24, v);
    close_frame();
    check("R7 shadow delivered", v, 32'h222222);
    check("R6 drdy low after read", drdy, 0);
    push(24'h333333);
    open_frame(1'b1, 1'b1);
    read_bits(4, v);
    push(24'h444444);
    close_frame();
    check("R7 drdy after aborted read", drdy, 1);
    open_frame(1'b1, 1'b1);
    read_bits(24, v);
    close_frame();
    check("R7 shadow after abort", v, 32'h444444);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    push(24'h555555);
    open_frame(1'b1, 1'b1);
    read_bits(23, v);
    @(negedge clk); sclk = 1'b1;
    wait_n(HP - 1);
    v = {v[30:0], sdo};
    sclk = 1'b0;
    // two sync stages later the falling edge is seen; strobe lands with it
    wait_n(2);
    res = 24'h666666; res_vld = 1'b1;
    @(negedge clk); res_vld = 1'b0;
    wait_n(HP);
    check("R9 word read", v, 32'h555555);
    close_frame();
    check("R9 drdy high", drdy, 1);
    open_frame(1'b1, 1'b1);
    read_bits(24, v);
    close_frame();
    check("R9 new result", v, 32'h666666);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_idle();
    t_write();
    t_abort();
    t_data_read();
    t_status();
    t_shadow();
    t_collide();
    all_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule